// File: doc/BRIEF.md
# Retimed Glitch-Free Phase Selector

This block sits between the select decoder and the phase multiplexer of a phase-switching frequency divider. It receives `N_PH` equally spaced copies of a divided clock (phase k+1 lags phase k by one fast-clock cycle) together with a one-hot select word. It returns one multiplexer enable per phase and a copy of every phase delayed by exactly as many cycles as the enable path, so that enables and phases reach the multiplexer together. Everything is modelled synchronously: the phases are levels sampled on the fast input clock.

Each phase has its own small state machine. It changes its enable only while its own phase is high, so the merged output OR(en & phase) never shows a runt pulse or an extra edge. This holds however early or late the select change arrives relative to the phases. Each handover to the next, later phase stretches one output period by a single fast cycle, which is how input cycles are swallowed.

Per-cell states: `CELL_IDLE` (not selected, enable off), `CELL_WAIT` (selected, waiting for its phase to be high), `CELL_LIVE` (enable on). Transitions: ARM (IDLE to WAIT, select seen while the phase is low), SEIZE (IDLE or WAIT to LIVE, select and phase both high), DISARM (WAIT to IDLE, select withdrawn), YIELD (LIVE to IDLE, the next phase is selected and high).

Top module: `retimed_phase_sel`

## Requirements
- R1: While reset is held, `en_o` is 1 only in bit 0, meaning phase 0 is enabled, and `phase_o` is all zero.
- R2: `phase_o[k]` equals `phase_i[k]` as sampled `DLY` clock cycles earlier.
- R3: After reset, exactly one bit of `en_o` is set in every cycle.
- R4: `en_o[k]` turns on only in a cycle where `phase_o[k]` is 1, and the merged output was 1 in the cycle before.
- R5: When `en_o[k]` turns on, `en_o[(k-1) mod N_PH]` turns off in the same cycle. Control always passes to the next, later phase.
- R6: After `sel_i` moves to phase k, the enables stay as they are until the first sampled cycle in which both `sel_i[k]` and `phase_i[k]` are 1. The handover becomes visible on `en_o` exactly `DLY` cycles after that sample.
- R7: While `sel_i` selects the phase that is already enabled, `en_o` does not change.
- R8: The merged output OR(`en_o` & `phase_o`) never has a high or low run shorter than `N_PH`/2 cycles. The spacing between its rising edges is `N_PH` cycles, plus one cycle for each handover in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | N_PH | Phase levels; bit k+1 lags bit k by one cycle |
| sel_i | input | N_PH | One-hot select from the decoder |
| en_o | output | N_PH | Retimed one-hot multiplexer enables |
| phase_o | output | N_PH | Phases delayed to line up with `en_o` |

## Verification
The bench builds the block with `N_PH = 4` and `DLY = 2`. The depth of two means the enable path contains one pipeline stage after the state register, so the check on how enables and phases line up is not satisfied trivially by a single shared register. The spacing between select changes is drawn at random, with a few directed gaps at the start, so a select change lands on every quarter of the phase period: while the target phase is high in its first or second cycle, and while it is low. This drives every cell through both the direct seize and the waiting path, and across the wrap from the last phase back to phase 0.

// File: rtl/retimed_phase_sel_pkg.sv
package retimed_phase_sel_pkg;

    typedef enum logic [1:0] {
        CELL_IDLE = 2'd0,
        CELL_WAIT = 2'd1,
        CELL_LIVE = 2'd2
    } cell_state_e;

endpackage

// File: rtl/rps_delay_line.sv
module rps_delay_line #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] rst_val_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_regs
            logic [WIDTH-1:0] pipe_q [STAGES];
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) begin
                        pipe_q[s] <= rst_val_i;
                    end else if (s == 0) begin
                        pipe_q[s] <= d_i;
                    end else begin
                        pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
                    end
                end
            end
            assign q_o = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rps_phase_cell.sv
module rps_phase_cell
    import retimed_phase_sel_pkg::*;
#(
    parameter bit START_LIVE = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic phase_i,
    input  logic sel_i,
    input  logic yield_i,
    output logic live_o
);

    cell_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= START_LIVE ? CELL_LIVE : CELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: every move of the enable happens only while this phase is high
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (sel_i && phase_i) begin
                    state_d = CELL_LIVE;        // SEIZE
                end else if (sel_i) begin
                    state_d = CELL_WAIT;        // ARM
                end
            end
            CELL_WAIT: begin
                if (!sel_i) begin
                    state_d = CELL_IDLE;        // DISARM
                end else if (phase_i) begin
                    state_d = CELL_LIVE;        // SEIZE
                end
            end
            CELL_LIVE: begin
                if (yield_i) begin
                    state_d = CELL_IDLE;        // YIELD
                end
            end
            default: state_d = CELL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        live_o = (state_q == CELL_LIVE);
    end

endmodule

// File: rtl/retimed_phase_sel.sv
module retimed_phase_sel #(
    parameter int N_PH = 4,
    parameter int DLY  = 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_PH-1:0] phase_i,
    input  logic [N_PH-1:0] sel_i,
    output logic [N_PH-1:0] en_o,
    output logic [N_PH-1:0] phase_o
);

    localparam int EN_EXTRA = DLY - 1;
    localparam logic [N_PH-1:0] EN_RESET = {{(N_PH-1){1'b0}}, 1'b1};

    logic [N_PH-1:0] live;
    logic [N_PH-1:0] yield;

    generate
        for (genvar k = 0; k < N_PH; k++) begin : g_cell
            localparam int NXT = (k + 1) % N_PH;
            // the outgoing cell yields on the very condition that lets the next one seize
            assign yield[k] = sel_i[NXT] & phase_i[NXT];

            rps_phase_cell #(
                .START_LIVE(k == 0)
            ) cell_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .phase_i(phase_i[k]),
                .sel_i  (sel_i[k]),
                .yield_i(yield[k]),
                .live_o (live[k])
            );
        end
    endgenerate

    rps_delay_line #(
        .WIDTH (N_PH),
        .STAGES(EN_EXTRA)
    ) en_dly_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rst_val_i(EN_RESET),
        .d_i      (live),
        .q_o      (en_o)
    );

    rps_delay_line #(
        .WIDTH (N_PH),
        .STAGES(DLY)
    ) ph_dly_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rst_val_i('0),
        .d_i      (phase_i),
        .q_o      (phase_o)
    );

endmodule

// File: rtl/retimed_phase_sel_chk.sv
module retimed_phase_sel_chk #(
    parameter int N_PH = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [N_PH-1:0] en_o,
    input logic [N_PH-1:0] phase_o
);

    logic merged;
    assign merged = |(en_o & phase_o);

    a_r3_one_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(en_o) == 1);

    a_r8_no_short_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(merged) |-> $past(merged, 2));

    a_r8_no_short_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(merged) |-> !$past(merged, 2));

    generate
        for (genvar k = 0; k < N_PH; k++) begin : g_k
            localparam int PRV = (k + N_PH - 1) % N_PH;

            a_r4_seize_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(en_o[k]) |-> phase_o[k] && $past(merged));

            a_r5_yield_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(en_o[k]) |-> $fell(en_o[PRV]));
        end
    endgenerate

endmodule

bind retimed_phase_sel retimed_phase_sel_chk #(.N_PH(N_PH)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_o   (en_o),
    .phase_o(phase_o)
);

// File: tb/retimed_phase_sel_tb_top.sv
module retimed_phase_sel_tb_top;

    localparam int N    = 4;
    localparam int DLY  = 2;
    localparam int ITER = 3000;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] phase_i = '0;
    logic [N-1:0] sel_i = 4'b0001;
    logic [N-1:0] en_o, phase_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    retimed_phase_sel #(.N_PH(N), .DLY(DLY)) dut_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .phase_i(phase_i),
        .sel_i  (sel_i),
        .en_o   (en_o),
        .phase_o(phase_o)
    );

    function automatic logic [N-1:0] phase_word(int t);
        logic [N-1:0] w;
        for (int k = 0; k < N; k++) w[k] = (((t + N - k) % N) < N/2);
        return w;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [N-1:0] hist [ITER];
    int gaps [4] = '{9, 10, 11, 12};

    initial begin
        logic [N-1:0] cur_en, exp_en, prev_en;
        logic         mux_now, mux_prev;
        int           tgt, expect_at, countdown, last_rise, hand_cnt, n_dir;
        bit           pending, seen_rise;
        int unsigned  seed;
        seed = $urandom(32'h1d2c3b4a);
        cur_en = 4'b0001; prev_en = 4'b0001;
        pending = 0; expect_at = -1; countdown = 6; n_dir = 0;
        mux_prev = 0; seen_rise = 0; last_rise = 0; hand_cnt = 0; tgt = 0;

        repeat (4) @(negedge clk_i);
        check(en_o == 4'b0001, "R1 en_o in reset", int'(en_o), 1);
        check(phase_o == '0, "R1 phase_o in reset", int'(phase_o), 0);

        for (int i = 0; i < ITER; i++) begin
            if (i > 0) @(negedge clk_i);
            if (i > 0) begin
                // R2 delay alignment
                exp_en = (i >= DLY) ? hist[i-DLY] : '0;
                check(phase_o == exp_en, "R2 phase delay", int'(phase_o), int'(exp_en));
                // R6 / R7 timing of the enable
                if (i == expect_at) cur_en = (N'(1) << tgt);
                check(en_o == cur_en, (i == expect_at || pending) ? "R6 handover timing" : "R7 enable held",
                      int'(en_o), int'(cur_en));
                check($countones(en_o) == 1, "R3 one enable", int'(en_o), int'(cur_en));
                mux_now = |(en_o & phase_o);
                if (en_o != prev_en) begin
                    hand_cnt++;
                    check(((en_o & phase_o) != '0) && mux_prev, "R4 seize in window",
                          int'(en_o & phase_o), int'(en_o));
                    check(en_o == {prev_en[N-2:0], prev_en[N-1]}, "R5 next phase",
                          int'(en_o), int'({prev_en[N-2:0], prev_en[N-1]}));
                end
                if (mux_now && !mux_prev) begin
                    if (seen_rise)
                        check((i - last_rise) == N + hand_cnt, "R8 edge spacing",
                              i - last_rise, N + hand_cnt);
                    seen_rise = 1; last_rise = i; hand_cnt = 0;
                end
                mux_prev = mux_now;
                prev_en = en_o;
            end

            // drive
            rst_ni  = 1'b1;
            phase_i = phase_word(i);
            hist[i] = phase_i;
            if (!pending && i > expect_at) begin
                if (countdown == 0) begin
                    for (int k = 0; k < N; k++) if (cur_en[k]) tgt = (k + 1) % N;
                    sel_i = N'(1) << tgt;
                    pending = 1;
                    if (n_dir < 4) begin countdown = gaps[n_dir]; n_dir++; end
                    else countdown = 8 + int'($urandom_range(19, 0));
                end else begin
                    countdown--;
                end
            end
            if (pending && sel_i[tgt] && phase_i[tgt]) begin
                expect_at = i + DLY;
                pending = 0;
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule